// File: doc/BRIEF.md
# Serial Control Register Port

This block is a write-only control port with three wires. The wires are an active-low chip select, a serial clock and a serial data input. A host lowers chip select and shifts one 16-bit frame in, most significant bit first. Each bit is taken on a rising edge of the serial clock. The host then raises chip select. The frame has three parts. The first part is a two-bit device code, which must be `01`. The second is a direction bit, which must be `1` (write). The last part is a 5-bit register index followed by one data byte. A frame that passes every check writes its byte into one of five 8-bit control registers. Each register field appears on its own output port, where the audio datapath can use it.

The three serial wires reach the block in the domain of the host. Each wire is re-timed into the system clock through a two-flop synchroniser. All edge detection happens after that point, so the system clock must run several times faster than the serial clock.

The active-low power-down input returns every register to its power-on value. The block ignores all writes while power-down is asserted. It also ignores all writes while the master-clock-present input is low.

Top module: `ctl_serial_regbank`

## Requirements
- R1: After reset, the register values are 0x8B for index 0, 0x02 for index 1, 0x00 for index 2, and 0xFF for indices 3 and 4. The outputs show these values: auto clock 1, format 3'b010, power enable 1, run 1, mute 0, de-emphasis 2'b01, zero-flag invert 0, both levels 0xFF.
- R2: A frame is 16 bits, MSB first. Bits 15..14 hold the device code `01`, bit 13 is the direction bit `1`, bits 12..8 hold the register index and bits 7..0 hold the data. The fields map as follows. Index 0: bit 7 auto clock, bits 4..2 format, bit 1 power enable, bit 0 run. Index 1: bit 7 zero-detect enable, bit 6 zero-detect AND mode, bit 5 slow filter, bits 4..3 speed, bits 2..1 de-emphasis, bit 0 soft mute. Index 2: bit 2 zero-flag invert. Index 3: left level. Index 4: right level.
- R3: A write changes the outputs only after chip select rises. While the frame is still open, after all 16 bits have been shifted in, the outputs keep their previous values.
- R4: A frame whose device code is not `01` changes no output.
- R5: A frame whose direction bit is `0` changes no output.
- R6: A frame of any bit count other than exactly 16 changes no output. This includes counts of 15 and 17.
- R7: A frame addressed to an index from 5 to 31 changes no output.
- R8: While the power-down input is low, every register holds its R1 value, and frames sent during that time change nothing.
- R9: While the master-clock-present input is low, frames change no output.
- R10: A write is accepted even when the power-enable bit and the run bit are both 0.
- R11: Clearing the run bit does not disturb the contents of any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Power-down, active low; restores register values and blocks writes |
| mclk_present | input | 1 | High when a master clock is running; low blocks writes |
| sel_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial bit clock |
| sdin | input | 1 | Serial data input |
| auto_clk | output | 1 | Automatic clock-ratio detection |
| fmt_sel | output | 3 | Audio data format select |
| pwr_en | output | 1 | Power enable |
| core_run | output | 1 | Internal timing run (0 holds timing in reset) |
| zd_en | output | 1 | Zero-detect enable |
| zd_and | output | 1 | Zero-detect uses both channels together |
| slow_flt | output | 1 | Slow roll-off filter select |
| spd_sel | output | 2 | Sampling speed select |
| deemph | output | 2 | De-emphasis select |
| soft_mute | output | 1 | Soft mute request |
| zflag_inv | output | 1 | Zero-flag polarity invert |
| lvl_left | output | 8 | Left channel level |
| lvl_right | output | 8 | Right channel level |

## Verification
Several properties are checked on every cycle:
- the commit strobe is a single-cycle pulse;
- the strobe never fires for an index above 4, or while power-down is asserted or the master clock is absent;
- the registers hold steady whenever no strobe arrives;
- power-down forces the power-on values;
- a strobe to the left level lands on that output in the next cycle.

Other behaviour can only be shown by the bench's scenarios. These are the field layout of every register, masking of the unused bits, rejection by device code, direction bit and bit count, and writes that succeed after the run and power bits have been cleared. The bench runs a full sweep over all 32 indices and every header combination, and compares the outputs with a model built from the requirements.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int CTL_DATA_W  = 8;
  localparam int CTL_ADDR_W  = 5;
  localparam int CTL_NREGS   = 5;
  localparam int CTL_CHIP_W  = 2;
  localparam int CTL_FRAME_W = CTL_CHIP_W + 1 + CTL_ADDR_W + CTL_DATA_W;

  typedef struct packed {
    logic [CTL_ADDR_W-1:0] addr;
    logic [CTL_DATA_W-1:0] data;
  } ctl_wr_t;

  // Power-on value of each register.
  function automatic logic [CTL_DATA_W-1:0] ctl_reg_default(input int idx);
    case (idx)
      0:       return 8'h8B;
      1:       return 8'h02;
      2:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // Bits that are implemented in each register.
  function automatic logic [CTL_DATA_W-1:0] ctl_reg_mask(input int idx);
    case (idx)
      0:       return 8'h9F;
      2:       return 8'h04;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [CTL_NREGS*CTL_DATA_W-1:0] ctl_default_flat();
    logic [CTL_NREGS*CTL_DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < CTL_NREGS; i++) v[i*CTL_DATA_W +: CTL_DATA_W] = ctl_reg_default(i);
    return v;
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ctl_frame_rx.sv
module ctl_frame_rx
  import ctl_pkg::*;
#(
  parameter logic [CTL_CHIP_W-1:0] CHIP_ID = 2'b01
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    port_en,
  input  logic    sel_s,
  input  logic    sclk_s,
  input  logic    sdin_s,
  output logic    wr_stb,
  output ctl_wr_t wr_req
);
  localparam int ADDR_LSB = CTL_DATA_W;
  localparam int DIR_POS  = CTL_DATA_W + CTL_ADDR_W;
  localparam int CHIP_LSB = DIR_POS + 1;
  localparam int CNT_MAX  = CTL_FRAME_W + 1;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  logic                   sel_d_q, sclk_d_q;
  logic [CTL_FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   stb_d;
  ctl_wr_t                req_d;
  logic                   sel_fall, sel_rise, sclk_rise, frame_ok;

  always_comb begin
    sel_fall  = sel_d_q & ~sel_s;
    sel_rise  = ~sel_d_q & sel_s;
    sclk_rise = ~sclk_d_q & sclk_s;

    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (sel_fall) begin
      cnt_d = '0;
    end else if (!sel_s && sclk_rise) begin
      shreg_d = {shreg_q[CTL_FRAME_W-2:0], sdin_s};
      cnt_d   = (cnt_q == CNT_W'(CNT_MAX)) ? cnt_q : cnt_q + 1'b1;
    end

    frame_ok = (cnt_q == CNT_W'(CTL_FRAME_W))
             && (shreg_q[CHIP_LSB +: CTL_CHIP_W] == CHIP_ID)
             && shreg_q[DIR_POS]
             && (shreg_q[ADDR_LSB +: CTL_ADDR_W] < CTL_ADDR_W'(CTL_NREGS));

    stb_d      = sel_rise & frame_ok & port_en;
    req_d.addr = shreg_q[ADDR_LSB +: CTL_ADDR_W];
    req_d.data = shreg_q[0 +: CTL_DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d_q  <= 1'b1;
      sclk_d_q <= 1'b0;
      shreg_q  <= '0;
      cnt_q    <= '0;
      wr_stb   <= 1'b0;
      wr_req   <= '0;
    end else begin
      sel_d_q  <= sel_s;
      sclk_d_q <= sclk_s;
      shreg_q  <= shreg_d;
      cnt_q    <= cnt_d;
      wr_stb   <= stb_d;
      if (stb_d) wr_req <= req_d;
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pwrdn_n,
  input  logic                            wr_stb,
  input  ctl_wr_t                         wr_req,
  output logic [CTL_NREGS*CTL_DATA_W-1:0] bank_q
);
  for (genvar gi = 0; gi < CTL_NREGS; gi++) begin : g_reg
    localparam logic [CTL_DATA_W-1:0] DEF  = ctl_reg_default(gi);
    localparam logic [CTL_DATA_W-1:0] MASK = ctl_reg_mask(gi);
    logic [CTL_DATA_W-1:0] r_q, r_d;
    logic                  hit;

    always_comb begin
      hit = wr_stb && (wr_req.addr == CTL_ADDR_W'(gi));
      r_d = r_q;
      if (!pwrdn_n) r_d = DEF;
      else if (hit) r_d = wr_req.data & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= DEF;
      else        r_q <= r_d;
    end

    assign bank_q[gi*CTL_DATA_W +: CTL_DATA_W] = r_q;
  end
endmodule

// File: rtl/ctl_serial_regbank.sv
module ctl_serial_regbank
  import ctl_pkg::*;
#(
  parameter int                    SYNC_STAGES = 2,
  parameter logic [CTL_CHIP_W-1:0] CHIP_ID     = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdn_n,
  input  logic       mclk_present,
  input  logic       sel_n,
  input  logic       sclk,
  input  logic       sdin,
  output logic       auto_clk,
  output logic [2:0] fmt_sel,
  output logic       pwr_en,
  output logic       core_run,
  output logic       zd_en,
  output logic       zd_and,
  output logic       slow_flt,
  output logic [1:0] spd_sel,
  output logic [1:0] deemph,
  output logic       soft_mute,
  output logic       zflag_inv,
  output logic [7:0] lvl_left,
  output logic [7:0] lvl_right
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] SYNC_RST = 3'b001;

  logic [NSIG-1:0] raw_in, sync_out;
  logic            sel_s, sclk_s, sdin_s, port_en, wr_stb;
  ctl_wr_t         wr_req;
  logic [CTL_NREGS*CTL_DATA_W-1:0] bank_q;
  logic [CTL_DATA_W-1:0] r0, r1, r2, r3, r4;

  assign raw_in = {sdin, sclk, sel_n};

  for (genvar gs = 0; gs < NSIG; gs++) begin : g_sync
    ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[gs])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in[gs]), .q(sync_out[gs])
    );
  end

  assign sel_s   = sync_out[0];
  assign sclk_s  = sync_out[1];
  assign sdin_s  = sync_out[2];
  assign port_en = pwrdn_n & mclk_present;

  ctl_frame_rx #(.CHIP_ID(CHIP_ID)) u_rx (
    .clk(clk), .rst_n(rst_n), .port_en(port_en),
    .sel_s(sel_s), .sclk_s(sclk_s), .sdin_s(sdin_s),
    .wr_stb(wr_stb), .wr_req(wr_req)
  );

  ctl_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
    .wr_stb(wr_stb), .wr_req(wr_req), .bank_q(bank_q)
  );

  assign r0 = bank_q[0*CTL_DATA_W +: CTL_DATA_W];
  assign r1 = bank_q[1*CTL_DATA_W +: CTL_DATA_W];
  assign r2 = bank_q[2*CTL_DATA_W +: CTL_DATA_W];
  assign r3 = bank_q[3*CTL_DATA_W +: CTL_DATA_W];
  assign r4 = bank_q[4*CTL_DATA_W +: CTL_DATA_W];

  assign auto_clk  = r0[7];
  assign fmt_sel   = r0[4:2];
  assign pwr_en    = r0[1];
  assign core_run  = r0[0];
  assign zd_en     = r1[7];
  assign zd_and    = r1[6];
  assign slow_flt  = r1[5];
  assign spd_sel   = r1[4:3];
  assign deemph    = r1[2:1];
  assign soft_mute = r1[0];
  assign zflag_inv = r2[2];
  assign lvl_left  = r3;
  assign lvl_right = r4;
endmodule

// File: rtl/ctl_serial_regbank_chk.sv
module ctl_serial_regbank_chk
  import ctl_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            pwrdn_n,
  input logic                            mclk_present,
  input logic                            wr_stb,
  input ctl_wr_t                         wr_req,
  input logic [CTL_NREGS*CTL_DATA_W-1:0] bank_q
);
  localparam logic [CTL_NREGS*CTL_DATA_W-1:0] DEFS = ctl_default_flat();

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);                                            // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_n && !wr_stb) |=> $stable(bank_q));                      // R3
  AST_STB_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_req.addr < CTL_ADDR_W'(CTL_NREGS)));              // R7
  AST_STB_NOT_PWRDN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(pwrdn_n));                                     // R8
  AST_STB_NEEDS_MCLK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(mclk_present));                                // R9
  AST_PWRDN_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> (bank_q == DEFS));                                 // R1
  AST_LEFT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && pwrdn_n && wr_req.addr == 5'd3) |=>
      (bank_q[3*CTL_DATA_W +: CTL_DATA_W] == $past(wr_req.data)));  // R2
endmodule

bind ctl_serial_regbank ctl_serial_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .mclk_present(mclk_present),
  .wr_stb(wr_stb), .wr_req(wr_req), .bank_q(bank_q)
);

// File: tb/ctl_serial_regbank_test.sv
module ctl_serial_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk, rst_n, pwrdn_n, mclk_present, sel_n, sclk, sdin;
  logic       auto_clk, pwr_en, core_run, zd_en, zd_and, slow_flt, soft_mute, zflag_inv;
  logic [2:0] fmt_sel;
  logic [1:0] spd_sel, deemph;
  logic [7:0] lvl_left, lvl_right;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [7:0] model [5];

  ctl_serial_regbank uut (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .mclk_present(mclk_present),
    .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
    .auto_clk(auto_clk), .fmt_sel(fmt_sel), .pwr_en(pwr_en), .core_run(core_run),
    .zd_en(zd_en), .zd_and(zd_and), .slow_flt(slow_flt), .spd_sel(spd_sel),
    .deemph(deemph), .soft_mute(soft_mute), .zflag_inv(zflag_inv),
    .lvl_left(lvl_left), .lvl_right(lvl_right)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] def_of(input int i);
    case (i) 0: return 8'h8B; 1: return 8'h02; 2: return 8'h00; default: return 8'hFF; endcase
  endfunction
  function automatic logic [7:0] mask_of(input int i);
    case (i) 0: return 8'h9F; 2: return 8'h04; default: return 8'hFF; endcase
  endfunction

  function automatic logic [30:0] expect_vec();
    return {model[0][7], model[0][4:2], model[0][1], model[0][0], model[1],
            model[2][2], model[3], model[4]};
  endfunction
  function automatic logic [30:0] actual_vec();
    return {auto_clk, fmt_sel, pwr_en, core_run, zd_en, zd_and, slow_flt, spd_sel,
            deemph, soft_mute, zflag_inv, lvl_left, lvl_right};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 5; i++) model[i] = def_of(i);
  endtask
  task automatic model_write(input int a, input logic [7:0] d);
    if (a < 5) model[a] = d & mask_of(a);
  endtask

  task automatic check(input string req);
    logic [30:0] act, exp;
    act = actual_vec();
    exp = expect_vec();
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n, input bit release_cs);
    @(negedge clk);
    sel_n = 1'b0;
    repeat (HALF_BIT) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = v[i];
      repeat (HALF_BIT) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF_BIT) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF_BIT) @(negedge clk);
    if (release_cs) begin
      sel_n = 1'b1;
      repeat (12) @(negedge clk);
    end
  endtask

  function automatic logic [15:0] frame(input logic [1:0] chip, input logic dir,
                                        input logic [4:0] a, input logic [7:0] d);
    return {chip, dir, a, d};
  endfunction

  task automatic write_ok(input int a, input logic [7:0] d);
    send_bits({16'h0, frame(2'b01, 1'b1, a[4:0], d)}, 16, 1'b1);
    model_write(a, d);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; pwrdn_n = 1'b1; mclk_present = 1'b1;
    sel_n = 1'b1; sclk = 1'b0; sdin = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset defaults");

    // R2 / R7: sweep all 32 indices with two data patterns
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 32; a++) begin
        logic [7:0] d;
        d = 8'((a * 53 + 7) ^ (pass * 8'hFF));
        write_ok(a, d);
        check(a < 5 ? "R2 field layout" : "R7 out-of-range index");
      end
    end

    // R3: outputs hold while frame open, change after release
    @(negedge clk);
    send_bits({16'h0, frame(2'b01, 1'b1, 5'd3, 8'h3C)}, 16, 1'b0);
    repeat (12) @(negedge clk);
    check("R3 held before release");
    sel_n = 1'b1;
    repeat (12) @(negedge clk);
    model_write(3, 8'h3C);
    check("R3 commit on release");

    // R4: wrong device codes; R5: read direction
    for (int c = 0; c < 4; c++) begin
      for (int dir = 0; dir < 2; dir++) begin
        if (!(c == 1 && dir == 1)) begin
          send_bits({16'h0, frame(2'(c), 1'(dir), 5'd4, 8'h11)}, 16, 1'b1);
          check(c != 1 ? "R4 device code reject" : "R5 direction reject");
        end
      end
    end

    // R6: wrong bit counts
    for (int n = 13; n <= 19; n++) begin
      if (n != 16) begin
        logic [31:0] v;
        logic [15:0] f;
        f = frame(2'b01, 1'b1, 5'd4, 8'h66);
        if (n > 16) v = {16'h0, f} | (32'h1 << 16);
        else        v = {16'h0, f} >> (16 - n);
        send_bits(v, n, 1'b1);
        check("R6 bit count reject");
      end
    end

    // R10 / R11: clear power and run bits, other registers keep, writes still land
    write_ok(1, 8'hA5);
    write_ok(0, 8'h00);
    check("R11 run bit clear keeps others");
    write_ok(4, 8'h5A);
    check("R10 write with power and run cleared");
    write_ok(2, 8'hFF);
    check("R10 index 2 masked write");

    // R9: no master clock
    mclk_present = 1'b0;
    send_bits({16'h0, frame(2'b01, 1'b1, 5'd3, 8'h01)}, 16, 1'b1);
    check("R9 write without master clock");
    mclk_present = 1'b1;
    write_ok(3, 8'h77);
    check("R9 write after clock returns");

    // R8: power-down restores defaults and blocks writes
    @(negedge clk);
    pwrdn_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R8 power-down defaults");
    send_bits({16'h0, frame(2'b01, 1'b1, 5'd3, 8'h12)}, 16, 1'b1);
    check("R8 write during power-down");
    pwrdn_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 after power-down release");
    write_ok(1, 8'h18);
    check("R8 write after power-up");

    done = 1;
    finish_run();
  end
endmodule